// File: doc/BRIEF.md
# Parallel Display Bus Cycle Generator

This block drives an 8080-style parallel bus towards a display controller that keeps its own frame buffer. A host writes a word into one of three action ports, and the block then runs one bus cycle: a command write, a parameter or data write, or a read. During the cycle it moves an active-low chip select, an active-low write strobe and an active-low read strobe, sets the command/data select line, and drives or samples the data bus. Every edge of every strobe is placed by its own tick count, taken from two packed timing words. One tick is one or two clocks of the interface clock.

The host side is a plain register port. Address 0 holds the configuration, address 1 the strobe edge word and address 2 the period word. A write to address 3 starts a command cycle, a write to address 4 starts a parameter cycle, and any write to address 5 starts a read cycle. Reading address 5 returns the last sampled bus value. The block repairs timing values that break the edge ordering rules before it uses them, so a bad setting cannot produce a strobe that never rises or a cycle that ends before its strobes do.

The sequencer has three states. It leaves `ST_IDLE` for `ST_WRITE` when a command or parameter port write is accepted. It leaves `ST_IDLE` for `ST_READ` when a read port write is accepted. It returns from `ST_WRITE` or `ST_READ` to `ST_IDLE` when the last tick of the cycle finishes. No other transitions exist.

Top module: `pbus_cycle_gen`

## Requirements
- R1: After reset, `cs_n`, `we_n` and `re_n` are high, `busy` and `bus_oe` are low, `dc_sel` is high, the configuration register reads 0x3 and both timing words read 0.
- R2: A write to address 3 runs a command cycle. `dc_sel` is low for the whole cycle. `we_n` is low from tick WE-on up to tick WE-off, and `cs_n` is low from tick CS-on up to tick CS-off. The strobe edge word at address 1 holds CS-on in bits 3:0, CS-off in bits 9:4, WE-on in bits 13:10, WE-off in bits 19:14, RE-on in bits 23:20 and RE-off in bits 29:24.
- R3: A write to address 4 runs a data cycle that behaves like a command cycle, except that `dc_sel` is high for the whole cycle. In every write cycle `bus_oe` is high and `bus_out` carries the written word from the first clock of the cycle to its last clock, and `re_n` stays high.
- R4: A write of any value to address 5 runs a read cycle. In a read cycle `re_n` is low from tick RE-on up to tick RE-off, `we_n` stays high and `bus_oe` stays low. `bus_in` is sampled on the first clock of tick access-time, and that sample is then returned when address 5 is read.
- R5: One tick lasts one clock when configuration bit 4 is 0 and two clocks when it is 1. All strobe edges and cycle lengths scale with this tick length.
- R6: The block repairs the programmed edges before use. An off count that is not above its on count becomes on+1, for each of WE, RE and CS. CS-off is then raised to at least the repaired WE-off and RE-off. The access time is raised to at least RE-on+1.
- R7: The period word at address 2 holds the write cycle time in bits 5:0, the read cycle time in bits 11:6 and the access time in bits 27:22. A write cycle lasts max(write cycle time, WE-off, CS-off) ticks. A read cycle lasts max(read cycle time, RE-off, CS-off, access+1) ticks. `busy` is high for exactly that many clocks, scaled by the tick length.
- R8: A host write that arrives while `busy` is high is held rather than lost. `host_stall` is high while it waits, no register changes, and the write takes effect on the first clock after `busy` falls.
- R9: Configuration bits 1:0 equal to 3 select a 16-bit bus. Any other value selects an 8-bit bus: `bus_out[15:8]` is driven as zero and the read sample takes only `bus_in[7:0]`, with the upper byte returned as zero.
- R10: Reads of addresses 0, 1 and 2 return the stored configuration and timing words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write request, held until not stalled |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read-back of the addressed register |
| host_stall | output | 1 | Host write is waiting for the bus |
| busy | output | 1 | A bus cycle is in progress |
| cs_n | output | 1 | Chip select, active low |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| dc_sel | output | 1 | Command/data select, low for command |
| bus_out | output | 16 | Data driven onto the panel bus |
| bus_oe | output | 1 | Output enable for `bus_out` |
| bus_in | input | 16 | Data returned by the panel |

## Verification
The assertions check, on every clock, that all strobes and the bus enable are quiet while idle, that the write and read strobes are never low together, that the bus is never driven while the read strobe is low, that `dc_sel` does not move inside a cycle, and that a stalled write leaves the registers untouched. The exact tick on which each edge falls, the repair of out-of-order edges, the scaling by the divider, the cycle lengths, the lane masking of the 8-bit mode and the value captured at the access tick can only be shown by the bench's scenarios. For these, the bench counts the low clocks and the first low clock of each strobe and compares them with values it works out from the programmed words.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
    localparam int ON_W  = 4;
    localparam int OFF_W = 6;
    localparam int END_W = OFF_W + 1;
    localparam int HOST_W = 32;

    localparam logic [2:0] ADDR_CFG    = 3'd0;
    localparam logic [2:0] ADDR_STROBE = 3'd1;
    localparam logic [2:0] ADDR_PERIOD = 3'd2;
    localparam logic [2:0] ADDR_CMD    = 3'd3;
    localparam logic [2:0] ADDR_PARAM  = 3'd4;
    localparam logic [2:0] ADDR_READ   = 3'd5;

    // bit positions the host software packs against
    localparam int P_CS_ON  = 0;
    localparam int P_CS_OFF = 4;
    localparam int P_WE_ON  = 10;
    localparam int P_WE_OFF = 14;
    localparam int P_RE_ON  = 20;
    localparam int P_RE_OFF = 24;
    localparam int P_WR_CYC = 0;
    localparam int P_RD_CYC = 6;
    localparam int P_ACC    = 22;
    localparam int P_DIV2   = 4;

    localparam logic [HOST_W-1:0] CFG_RESET = 32'h0000_0003;

    typedef struct packed {
        logic [ON_W-1:0]  cs_on;
        logic [ON_W-1:0]  we_on;
        logic [ON_W-1:0]  re_on;
        logic [OFF_W-1:0] cs_off;
        logic [OFF_W-1:0] we_off;
        logic [OFF_W-1:0] re_off;
        logic [OFF_W-1:0] wr_cyc;
        logic [OFF_W-1:0] rd_cyc;
        logic [OFF_W-1:0] acc;
    } raw_timing_t;

    typedef struct packed {
        logic [OFF_W-1:0] cs_on;
        logic [OFF_W-1:0] cs_off;
        logic [OFF_W-1:0] we_on;
        logic [OFF_W-1:0] we_off;
        logic [OFF_W-1:0] re_on;
        logic [OFF_W-1:0] re_off;
        logic [OFF_W-1:0] acc;
        logic [END_W-1:0] wr_end;
        logic [END_W-1:0] rd_end;
    } edge_set_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/pbus_host_regs.sv
module pbus_host_regs
    import pbus_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [2:0]        host_addr,
    input  logic [HOST_W-1:0] host_wdata,
    input  logic              busy,
    input  logic [DATA_W-1:0] rd_value,
    output logic [HOST_W-1:0] host_rdata,
    output logic              host_stall,
    output logic              wide,
    output logic              div2,
    output raw_timing_t       raw,
    output logic              go_cmd,
    output logic              go_param,
    output logic              go_read,
    output logic [DATA_W-1:0] go_data
);
    logic [HOST_W-1:0] cfg_q, strobe_q, period_q;
    logic              accept;

    assign accept     = host_wr && !busy;
    assign host_stall = host_wr && busy;
    assign go_cmd     = accept && (host_addr == ADDR_CMD);
    assign go_param   = accept && (host_addr == ADDR_PARAM);
    assign go_read    = accept && (host_addr == ADDR_READ);
    assign go_data    = host_wdata[DATA_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q    <= CFG_RESET;
            strobe_q <= '0;
            period_q <= '0;
        end else if (accept) begin
            if (host_addr == ADDR_CFG)    cfg_q    <= host_wdata;
            if (host_addr == ADDR_STROBE) strobe_q <= host_wdata;
            if (host_addr == ADDR_PERIOD) period_q <= host_wdata;
        end
    end

    assign wide = (cfg_q[1:0] == 2'b11);
    assign div2 = cfg_q[P_DIV2];

    always_comb begin
        raw.cs_on  = strobe_q[P_CS_ON  +: ON_W];
        raw.cs_off = strobe_q[P_CS_OFF +: OFF_W];
        raw.we_on  = strobe_q[P_WE_ON  +: ON_W];
        raw.we_off = strobe_q[P_WE_OFF +: OFF_W];
        raw.re_on  = strobe_q[P_RE_ON  +: ON_W];
        raw.re_off = strobe_q[P_RE_OFF +: OFF_W];
        raw.wr_cyc = period_q[P_WR_CYC +: OFF_W];
        raw.rd_cyc = period_q[P_RD_CYC +: OFF_W];
        raw.acc    = period_q[P_ACC    +: OFF_W];
    end

    always_comb begin
        unique case (host_addr)
            ADDR_CFG:    host_rdata = cfg_q;
            ADDR_STROBE: host_rdata = strobe_q;
            ADDR_PERIOD: host_rdata = period_q;
            ADDR_READ:   host_rdata = {{(HOST_W-DATA_W){1'b0}}, rd_value};
            default:     host_rdata = '0;
        endcase
    end

    // R8: a write held off by a running cycle must not touch the registers
    assert_stall_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && busy) |=> ($stable(cfg_q) && $stable(strobe_q) && $stable(period_q)));
endmodule

// File: rtl/pbus_edge_fix.sv
module pbus_edge_fix
    import pbus_pkg::*;
(
    input  raw_timing_t raw,
    output edge_set_t   edges
);
    function automatic logic [OFF_W-1:0] past_on(input logic [OFF_W-1:0] on_t,
                                                 input logic [OFF_W-1:0] off_t);
        return (off_t <= on_t) ? on_t + 1'b1 : off_t;
    endfunction

    function automatic logic [OFF_W-1:0] max6(input logic [OFF_W-1:0] a,
                                              input logic [OFF_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [END_W-1:0] max7(input logic [END_W-1:0] a,
                                              input logic [END_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

    logic [OFF_W-1:0] cs_on_w, we_on_w, re_on_w;
    logic [OFF_W-1:0] we_off_f, re_off_f, cs_off_a, cs_off_f;
    logic [OFF_W-1:0] wc_f, rc_f, acc_f;
    logic [END_W-1:0] rd_base;

    always_comb begin
        cs_on_w  = {{(OFF_W-ON_W){1'b0}}, raw.cs_on};
        we_on_w  = {{(OFF_W-ON_W){1'b0}}, raw.we_on};
        re_on_w  = {{(OFF_W-ON_W){1'b0}}, raw.re_on};
        we_off_f = past_on(we_on_w, raw.we_off);
        re_off_f = past_on(re_on_w, raw.re_off);
        cs_off_a = past_on(cs_on_w, raw.cs_off);
        cs_off_f = max6(cs_off_a, max6(we_off_f, re_off_f));
        wc_f     = max6(raw.wr_cyc, we_off_f);
        rc_f     = max6(raw.rd_cyc, re_off_f);
        acc_f    = past_on(re_on_w, raw.acc);
        rd_base  = max7({1'b0, rc_f}, {1'b0, cs_off_f});

        edges.cs_on  = cs_on_w;
        edges.cs_off = cs_off_f;
        edges.we_on  = we_on_w;
        edges.we_off = we_off_f;
        edges.re_on  = re_on_w;
        edges.re_off = re_off_f;
        edges.acc    = acc_f;
        edges.wr_end = max7({1'b0, wc_f}, {1'b0, cs_off_f});
        edges.rd_end = max7(rd_base, {1'b0, acc_f} + 1'b1);
    end
endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
    import pbus_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_cmd,
    input  logic              go_param,
    input  logic              go_read,
    input  logic [DATA_W-1:0] go_data,
    input  logic              wide,
    input  logic              div2,
    input  edge_set_t         edges,
    input  logic [DATA_W-1:0] bus_in,
    output logic              busy,
    output logic              cs_n,
    output logic              we_n,
    output logic              re_n,
    output logic              dc_sel,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic [DATA_W-1:0] rd_value
);
    localparam int LANE_W = DATA_W / 2;

    seq_state_e        state_q, state_d;
    logic [END_W-1:0]  tick_q;
    logic              sub_q, adv, last;
    logic [END_W-1:0]  cur_end;
    logic [DATA_W-1:0] dout_q, in_lane, out_lane;

    assign adv     = !div2 || sub_q;
    assign cur_end = (state_q == ST_READ) ? edges.rd_end : edges.wr_end;
    assign last    = (state_q != ST_IDLE) && adv && (tick_q == cur_end - 1'b1);

    // lane selection for 8-bit versus 16-bit bus
    generate
        if (LANE_W > 0) begin : g_lanes
            assign in_lane  = wide ? bus_in  : {{(DATA_W-LANE_W){1'b0}}, bus_in[LANE_W-1:0]};
            assign out_lane = wide ? go_data : {{(DATA_W-LANE_W){1'b0}}, go_data[LANE_W-1:0]};
        end else begin : g_single
            assign in_lane  = bus_in;
            assign out_lane = go_data;
        end
    endgenerate

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go_read)                 state_d = ST_READ;
                else if (go_cmd || go_param) state_d = ST_WRITE;
            end
            ST_WRITE: if (last) state_d = ST_IDLE;
            ST_READ:  if (last) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // tick counter and per-cycle data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q   <= '0;
            sub_q    <= 1'b0;
            dc_sel   <= 1'b1;
            dout_q   <= '0;
            rd_value <= '0;
        end else begin
            if (state_q == ST_IDLE) begin
                tick_q <= '0;
                sub_q  <= 1'b0;
                if (go_cmd || go_param) begin
                    dc_sel <= go_param;
                    dout_q <= out_lane;
                end
            end else if (adv) begin
                tick_q <= tick_q + 1'b1;
                sub_q  <= 1'b0;
            end else begin
                sub_q  <= 1'b1;
            end
            if (state_q == ST_READ && !sub_q && tick_q == {1'b0, edges.acc})
                rd_value <= in_lane;
        end
    end

    // outputs
    always_comb begin
        busy    = (state_q != ST_IDLE);
        cs_n    = !(busy && tick_q >= {1'b0, edges.cs_on} && tick_q < {1'b0, edges.cs_off});
        we_n    = !(state_q == ST_WRITE && tick_q >= {1'b0, edges.we_on}
                    && tick_q < {1'b0, edges.we_off});
        re_n    = !(state_q == ST_READ && tick_q >= {1'b0, edges.re_on}
                    && tick_q < {1'b0, edges.re_off});
        bus_oe  = (state_q == ST_WRITE);
        bus_out = bus_oe ? dout_q : '0;
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_n && we_n && re_n && !bus_oe));
    assert_no_read_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !re_n |-> !bus_oe);
    assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));
    assert_dc_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(dc_sel));
endmodule

// File: rtl/pbus_cycle_gen.sv
module pbus_cycle_gen
    import pbus_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [2:0]        host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              host_stall,
    output logic              busy,
    output logic              cs_n,
    output logic              we_n,
    output logic              re_n,
    output logic              dc_sel,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    input  logic [DATA_W-1:0] bus_in
);
    raw_timing_t       raw;
    edge_set_t         edges;
    logic              wide, div2, go_cmd, go_param, go_read;
    logic [DATA_W-1:0] go_data, rd_value;

    pbus_host_regs #(.DATA_W(DATA_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .busy(busy), .rd_value(rd_value),
        .host_rdata(host_rdata), .host_stall(host_stall), .wide(wide), .div2(div2),
        .raw(raw), .go_cmd(go_cmd), .go_param(go_param), .go_read(go_read),
        .go_data(go_data)
    );

    pbus_edge_fix fix_i (.raw(raw), .edges(edges));

    pbus_seq #(.DATA_W(DATA_W)) seq_i (
        .clk(clk), .rst_n(rst_n), .go_cmd(go_cmd), .go_param(go_param),
        .go_read(go_read), .go_data(go_data), .wide(wide), .div2(div2),
        .edges(edges), .bus_in(bus_in), .busy(busy), .cs_n(cs_n), .we_n(we_n),
        .re_n(re_n), .dc_sel(dc_sel), .bus_out(bus_out), .bus_oe(bus_oe),
        .rd_value(rd_value)
    );
endmodule

// File: tb/pbus_cycle_gen_tb_top.sv
module pbus_cycle_gen_tb_top;
    localparam int CLK_PERIOD = 10;

    function automatic logic [31:0] sw_of(int cson, int csoff, int weon, int weoff,
                                          int reon, int reoff);
        return 32'(cson) | (32'(csoff) << 4) | (32'(weon) << 10) | (32'(weoff) << 14)
             | (32'(reon) << 20) | (32'(reoff) << 24);
    endfunction

    function automatic logic [31:0] pw_of(int wcyc, int rcyc, int acc);
        return 32'(wcyc) | (32'(rcyc) << 6) | (32'(acc) << 22);
    endfunction

    typedef struct packed {
        logic [1:0]  kind;   // 0 command, 1 parameter, 2 read
        logic [31:0] cfg;
        logic [31:0] sw;
        logic [31:0] pw;
        logic [15:0] data;
        logic [15:0] din;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 32'h03, sw_of(1, 6, 2, 5, 0, 0), pw_of(8, 0, 0), 16'hA5C3, 16'h0000},
        '{2'd1, 32'h13, sw_of(0, 4, 1, 3, 0, 0), pw_of(4, 0, 0), 16'h1234, 16'h0000},
        '{2'd2, 32'h03, sw_of(0, 7, 0, 0, 1, 6), pw_of(0, 9, 4), 16'h0000, 16'hBEEF},
        '{2'd2, 32'h10, sw_of(0, 5, 0, 0, 2, 5), pw_of(0, 5, 9), 16'h0000, 16'hABCD},
        '{2'd0, 32'h00, sw_of(5, 2, 3, 1, 0, 0), pw_of(2, 0, 0), 16'h7E81, 16'h0000},
        '{2'd1, 32'h01, sw_of(0, 3, 0, 2, 0, 0), pw_of(3, 0, 0), 16'h55AA, 16'h0000},
        '{2'd2, 32'h03, sw_of(0, 0, 0, 0, 5, 3), pw_of(0, 0, 2), 16'h0000, 16'h4C1D}
    };

    logic        clk = 1'b0, rst_n = 1'b0, host_wr = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [31:0] host_wdata = '0, host_rdata;
    logic        host_stall, busy, cs_n, we_n, re_n, dc_sel, bus_oe;
    logic [15:0] bus_out, bus_in = '0;
    int n_chk = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pbus_cycle_gen dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_stall(host_stall),
        .busy(busy), .cs_n(cs_n), .we_n(we_n), .re_n(re_n), .dc_sel(dc_sel),
        .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [2:0] a, input logic [31:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        #1;
        while (host_stall) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        host_wr = 1'b0;
        #1;
    endtask

    // measured cycle profile
    int k, cs_f, cs_c, we_f, we_c, re_f, re_c, oe_c, dc_bad;
    logic [15:0] bus0;

    task automatic measure(input int want_dc);
        k = 0; cs_f = -1; cs_c = 0; we_f = -1; we_c = 0; re_f = -1; re_c = 0;
        oe_c = 0; dc_bad = 0; bus0 = bus_out;
        while (busy && k < 400) begin
            if (!cs_n) begin if (cs_f < 0) cs_f = k; cs_c++; end
            if (!we_n) begin if (we_f < 0) we_f = k; we_c++; end
            if (!re_n) begin if (re_f < 0) re_f = k; re_c++; end
            if (bus_oe) oe_c++;
            if (want_dc >= 0 && int'(dc_sel) != want_dc) dc_bad++;
            k++;
            @(negedge clk); #1;
        end
    endtask

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    task automatic run_vec(input vec_t v);
        int cson, csoff, weon, weoff, reon, reoff, wcyc, rcyc, acc, dv, tend;
        logic [15:0] exp_bus, exp_rd;
        bit wide;
        // R6 repair rules, worked out from the requirement text
        cson  = int'(v.sw[3:0]);   csoff = int'(v.sw[9:4]);
        weon  = int'(v.sw[13:10]); weoff = int'(v.sw[19:14]);
        reon  = int'(v.sw[23:20]); reoff = int'(v.sw[29:24]);
        wcyc  = int'(v.pw[5:0]);   rcyc  = int'(v.pw[11:6]); acc = int'(v.pw[27:22]);
        if (weoff <= weon) weoff = weon + 1;
        if (reoff <= reon) reoff = reon + 1;
        if (csoff <= cson) csoff = cson + 1;
        csoff = imax(csoff, imax(weoff, reoff));
        if (acc <= reon) acc = reon + 1;
        dv = v.cfg[4] ? 2 : 1;
        wide = (v.cfg[1:0] == 2'b11);
        if (v.kind == 2'd2) tend = imax(imax(imax(rcyc, reoff), csoff), acc + 1);
        else                tend = imax(imax(wcyc, weoff), csoff);
        exp_bus = wide ? v.data : {8'h00, v.data[7:0]};
        exp_rd  = wide ? v.din  : {8'h00, v.din[7:0]};

        hwrite(3'd0, v.cfg);
        hwrite(3'd1, v.sw);
        hwrite(3'd2, v.pw);
        bus_in = v.din;
        hwrite(v.kind == 2'd0 ? 3'd3 : (v.kind == 2'd1 ? 3'd4 : 3'd5), v.data);
        measure(v.kind == 2'd2 ? -1 : int'(v.kind));

        check(k == tend * dv, "R7 busy length", k, tend * dv);
        check(cs_f == cson * dv, "R2 cs_n first low clock", cs_f, cson * dv);
        check(cs_c == (csoff - cson) * dv, "R6 cs_n low clocks", cs_c, (csoff - cson) * dv);
        if (v.kind == 2'd2) begin
            check(we_c == 0 && oe_c == 0, "R4 no write strobe or drive in read", we_c + oe_c, 0);
            check(re_f == reon * dv, "R4 re_n first low clock", re_f, reon * dv);
            check(re_c == (reoff - reon) * dv, "R5 re_n low clocks", re_c, (reoff - reon) * dv);
            host_addr = 3'd5; #1;
            check(host_rdata == {16'h0, exp_rd}, "R9 read sample", int'(host_rdata), int'(exp_rd));
        end else begin
            check(re_c == 0, "R3 re_n idle in write", re_c, 0);
            check(we_f == weon * dv, "R2 we_n first low clock", we_f, weon * dv);
            check(we_c == (weoff - weon) * dv, "R5 we_n low clocks", we_c, (weoff - weon) * dv);
            check(oe_c == tend * dv, "R3 bus_oe clocks", oe_c, tend * dv);
            check(bus0 == exp_bus, "R9 bus_out lanes", int'(bus0), int'(exp_bus));
            check(dc_bad == 0, v.kind == 2'd0 ? "R2 dc_sel low" : "R3 dc_sel high", dc_bad, 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int st_c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1 reset state
        check(cs_n && we_n && re_n, "R1 strobes high", {cs_n, we_n, re_n}, 3'b111);
        check(!busy && !bus_oe && dc_sel, "R1 busy/oe/dc", {busy, bus_oe, dc_sel}, 3'b001);
        host_addr = 3'd0; #1;
        check(host_rdata == 32'h3, "R1 cfg reset", int'(host_rdata), 3);
        host_addr = 3'd1; #1;
        check(host_rdata == 32'h0, "R1 strobe word reset", int'(host_rdata), 0);

        // R10 register read-back
        hwrite(3'd1, 32'h3ABC_DE12);
        hwrite(3'd2, 32'h0FED_CBA9);
        host_addr = 3'd1; #1;
        check(host_rdata == 32'h3ABC_DE12, "R10 strobe word", int'(host_rdata), 32'h3ABC_DE12);
        host_addr = 3'd2; #1;
        check(host_rdata == 32'h0FED_CBA9, "R10 period word", int'(host_rdata), 32'h0FED_CBA9);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R8 write during a running cycle is held, then executed
        hwrite(3'd0, 32'h3);
        hwrite(3'd1, sw_of(0, 3, 0, 2, 0, 0));
        hwrite(3'd2, pw_of(10, 0, 0));
        hwrite(3'd3, 32'h1111);
        host_addr = 3'd4; host_wdata = 32'h2222; host_wr = 1'b1; #1;
        st_c = 0;
        while (host_stall && st_c < 100) begin st_c++; @(negedge clk); #1; end
        check(st_c == 10, "R8 stall clocks", st_c, 10);
        @(posedge clk); @(negedge clk); host_wr = 1'b0; #1;
        check(busy && dc_sel && bus_out == 16'h2222, "R8 held write executes",
              int'(bus_out), 16'h2222);
        measure(1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule